// File: doc/BRIEF.md
# Error-Tagged Receive Character Buffer

This block is the receive-side character store of one serial port channel. The deserializer hands it one character at a time, together with its parity-error, framing-error and break indications. The block keeps up to 512 such entries in arrival order. When a character arrives and no room is left, that character is lost, and the most recent stored entry is marked as the last good character before the loss. The host drains the buffer through a valid/ready read port, and each read returns the character and its four tags together in one 16-bit word.

The block also exposes its current fill level as a 16-bit count. It drives a data request whenever that level reaches a threshold picked by a 2-bit code. A receive-enable input gates whether arrivals are accepted at all. A flush input empties the store and keeps it empty for as long as it is held.

Back-pressure rules: the input side has no ready. An arrival is taken in the cycle `in_valid` is high, unless the enable is low, a flush is active, or the store is full with no read in the same cycle. The output side presents `out_valid` whenever entries are held. A word is consumed on any cycle in which `out_valid` and `out_ready` are both high. The word does not depend on `out_ready`.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `out_valid` is 0, `out_word` is 0 and `rx_req` is 0.
- R2: Each accepted character is stored in arrival order. The output word places the character in bits 7:0, parity error in bit 8, overrun in bit 9, framing error in bit 10 and break in bit 11, with bits 15:12 zero. The input `in_err` carries parity in bit 0, framing in bit 1 and break in bit 2.
- R3: The store holds at most 512 entries. An arrival while 512 entries are held and no read is taken is discarded, and `fill_count` stays at 512.
- R4: A discarded arrival sets the overrun bit (bit 9) of the newest stored entry, and that bit is seen when the entry is read.
- R5: `out_ready` while the store is empty returns `out_word` = 0 with `out_valid` low, and `fill_count` is unchanged.
- R6: While `rx_en` is 0, arrivals are ignored and `fill_count` does not change.
- R7: While `flush` is 1, `fill_count` becomes 0 on the next edge and stays 0, `out_valid` is 0, and arrivals are ignored. After `flush` returns to 0, arrivals are stored again.
- R8: `trig_sel` code 1 sets the request threshold to 1 entry, code 2 to 256 entries and code 3 to 448 entries. Code 0 keeps `rx_req` low.
- R9: `rx_req` is high in exactly those cycles where `fill_count` is at or above the selected threshold. It falls in the same cycle the count drops below the threshold.
- R10: An arrival and a read in the same cycle at 512 entries both take effect, and the count stays at 512.
- R11: `fill_count` equals the number of stored entries. It changes on the clock edge that takes an arrival or a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Accept arrivals when 1 |
| flush | input | 1 | Empty the store while 1 |
| trig_sel | input | 2 | Request threshold code (0 off, 1, 2, 3) |
| in_valid | input | 1 | Character arrival strobe |
| in_char | input | 8 | Arriving character |
| in_err | input | 3 | Arrival tags: bit0 parity, bit1 framing, bit2 break |
| out_valid | output | 1 | At least one entry held |
| out_ready | input | 1 | Host consumes the presented word |
| out_word | output | 16 | Oldest entry with tags, 0 when empty |
| fill_count | output | 16 | Number of stored entries |
| rx_req | output | 1 | Fill level at or above threshold |

## Verification
Arrivals and reads take effect on the first rising edge after they are presented. `fill_count`, `out_valid` and `out_word` therefore show the new state one cycle after the stimulus. `rx_req` is derived combinationally from the count, so it settles in that same cycle. The bench drives inputs on the falling edge and keeps a software count and a queue of expected words. It compares the output word on the falling edge before the consuming edge, and it compares count and request on the falling edge after it, so every check lands exactly one cycle after its stimulus.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  function automatic logic [WORD_W-1:0] pack_word(rx_entry_t e, logic ovr);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = e.ch;
    w[8]     = e.perr;
    w[9]     = ovr;
    w[10]    = e.ferr;
    w[11]    = e.brk;
    return w;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  rx_entry_t     push_entry,
  input  logic          pop,
  output rx_entry_t     head_entry,
  output logic          head_ovr,
  output logic [CW-1:0] count
);
  rx_entry_t        mem [DEPTH];
  logic [DEPTH-1:0] ovr_tag;
  logic [AW-1:0]    wr_ptr, rd_ptr, last_ptr;
  logic             pop_ok, push_ok, overflow;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok   = pop && (count != '0) && !flush;
  assign push_ok  = push && !flush && ((count != CW'(DEPTH)) || pop_ok);
  assign overflow = push && !flush && (count == CW'(DEPTH)) && !pop_ok;
  assign last_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovr_tag <= '0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
    end else begin
      if (push_ok) begin
        ovr_tag[wr_ptr] <= 1'b0;
        wr_ptr          <= bump(wr_ptr);
      end
      if (overflow) ovr_tag[last_ptr] <= 1'b1;
      if (pop_ok) rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_entry = mem[rd_ptr];
  assign head_ovr   = ovr_tag[rd_ptr];

  // R3: never more than DEPTH entries
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3: arrival at full without read leaves count at DEPTH
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && push && !pop && !flush) |=> count == CW'(DEPTH));
  // R10: arrival and read together at full keep the level
  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && push && pop && !flush) |=> count == CW'(DEPTH));
  // R7: flush empties on the next edge
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  // R5: reading an empty store changes nothing
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !push) |=> count == '0);
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int CW   = 10,
  parameter int THR1 = 1,
  parameter int THR2 = 256,
  parameter int THR3 = 448
) (
  input  logic [CW-1:0] count,
  input  logic [1:0]    code,
  output logic          req
);
  logic [CW-1:0] thr;

  always_comb begin
    case (code)
      2'd1:    thr = CW'(THR1);
      2'd2:    thr = CW'(THR2);
      2'd3:    thr = CW'(THR3);
      default: thr = '0;
    endcase
  end

  assign req = (code != 2'd0) && (count >= thr);
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int THR1  = 1,
  parameter int THR2  = 256,
  parameter int THR3  = 448
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        flush,
  input  logic [1:0]  trig_sel,
  input  logic        in_valid,
  input  logic [7:0]  in_char,
  input  logic [2:0]  in_err,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_word,
  output logic [15:0] fill_count,
  output logic        rx_req
);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t     in_entry, head_entry;
  logic          head_ovr;
  logic [CW-1:0] count;

  assign in_entry = '{brk: in_err[2], ferr: in_err[1], perr: in_err[0], ch: in_char};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push       (in_valid && rx_en),
    .push_entry (in_entry),
    .pop        (out_ready),
    .head_entry (head_entry),
    .head_ovr   (head_ovr),
    .count      (count)
  );

  rxq_level #(.CW(CW), .THR1(THR1), .THR2(THR2), .THR3(THR3)) u_level (
    .count (count),
    .code  (trig_sel),
    .req   (rx_req)
  );

  assign out_valid  = (count != '0) && !flush;
  assign out_word   = out_valid ? pack_word(head_entry, head_ovr) : '0;
  assign fill_count = 16'(count);

  // R6: disabled receiver with no read keeps the level
  a_r6_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !out_ready && !flush) |=> $stable(fill_count));
  // R8: code 0 never requests
  a_r8_code0: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 2'd0) |-> !rx_req);
  // R5: empty output presents zero
  a_r5_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_word == 16'h0);
endmodule

// File: tb/rxq_tagged_fifo_tb.sv
module rxq_tagged_fifo_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_en = 0, flush = 0, in_valid = 0, out_ready = 0;
  logic [1:0]  trig_sel = 0;
  logic [7:0]  in_char = 0;
  logic [2:0]  in_err = 0;
  logic        out_valid, rx_req;
  logic [15:0] out_word, fill_count;

  int tests = 0, fails = 0;
  int cnt = 0;
  logic [15:0] sb [$];

  always #5 clk = ~clk;

  rxq_tagged_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .flush(flush), .trig_sel(trig_sel),
    .in_valid(in_valid), .in_char(in_char), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .fill_count(fill_count), .rx_req(rx_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int thr_of(logic [1:0] c);
    case (c) 2'd1: return 1; 2'd2: return 256; 2'd3: return 448; default: return -1; endcase
  endfunction

  // one cycle: drive at falling edge, monitor the head word, model, advance
  task automatic cycle(input logic push, input logic [7:0] ch, input logic [2:0] er,
                       input logic pop, input string req);
    logic pop_ok, push_ok;
    logic [15:0] w;
    in_valid = push; in_char = ch; in_err = er; out_ready = pop;
    #1;
    pop_ok  = pop && cnt > 0 && !flush;
    push_ok = push && rx_en && !flush && (cnt < 512 || pop_ok);
    if (pop) begin
      if (pop_ok) check({req, " R2 word"}, out_word, sb[0]);
      else        check({req, " R5 empty word"}, out_word, 16'h0);
    end
    if (push && rx_en && !flush && !push_ok) sb[$] = sb[$] | 16'h0200;
    if (pop_ok) begin w = sb.pop_front(); cnt--; end
    if (push_ok) begin sb.push_back({4'h0, er[2], er[1], 1'b0, er[0], ch}); cnt++; end
    if (flush) begin sb.delete(); cnt = 0; end
    @(posedge clk); @(negedge clk);
    in_valid = 0; out_ready = 0;
  endtask

  task automatic check_level(string req);
    int t;
    check({req, " R11 count"}, fill_count, cnt);
    t = thr_of(trig_sel);
    check({req, " R9 req"}, rx_req, (t > 0 && cnt >= t));
  endtask

  initial begin
    #500000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 count", fill_count, 0);
    check("R1 valid", out_valid, 0);
    check("R1 word", out_word, 0);
    check("R1 req", rx_req, 0);

    rx_en = 1; trig_sel = 2'd1;
    // R2 ordering and tag placement
    cycle(1, 8'h41, 3'b000, 0, "R2");
    check_level("R8 code1");
    cycle(1, 8'h5a, 3'b001, 0, "R2");
    cycle(1, 8'hc3, 3'b010, 0, "R2");
    cycle(1, 8'h07, 3'b100, 0, "R2");
    check_level("R2");
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, "R2");
    check_level("R9 fall to zero");

    // R5 empty read
    cycle(0, 0, 0, 1, "R5");
    check("R5 valid", out_valid, 0);
    check("R5 count", fill_count, 0);

    // R6 receiver disabled
    rx_en = 0;
    cycle(1, 8'h99, 3'b111, 0, "R6");
    check("R6 count", fill_count, 0);
    rx_en = 1;

    // R8 code 2 boundary
    trig_sel = 2'd2;
    for (int i = 0; i < 255; i++) cycle(1, 8'(i), 3'(i), 0, "R8");
    check_level("R8 code2 255");
    cycle(1, 8'hee, 0, 0, "R8");
    check_level("R8 code2 256");
    trig_sel = 2'd0; #1;
    check_level("R8 code0");
    // R8 code 3 boundary
    trig_sel = 2'd3;
    for (int i = 0; i < 191; i++) cycle(1, 8'(i + 3), 3'(i + 1), 0, "R8");
    check_level("R8 code3 447");
    cycle(1, 8'h3c, 0, 0, "R8");
    check_level("R8 code3 448");
    cycle(0, 0, 0, 1, "R9");
    check_level("R9 drop below");

    // R3 fill to full then overflow, R4 overrun tag
    for (int i = 0; i < 65; i++) cycle(1, 8'(i * 7), 3'(i), 0, "R3");
    check("R3 full count", fill_count, 512);
    cycle(1, 8'hab, 3'b111, 0, "R3");
    check("R3 drop count", fill_count, 512);
    cycle(1, 8'hcd, 3'b000, 0, "R4");
    // R10 simultaneous at full
    cycle(1, 8'h5e, 3'b001, 1, "R10");
    check("R10 count", fill_count, 512);

    // drain, every word compared incl. overrun-tagged newest entry (R4)
    while (cnt > 0) cycle(0, 0, 0, 1, "R4 drain");
    check_level("R11 empty");

    // R7 flush
    for (int i = 0; i < 5; i++) cycle(1, 8'(i + 16), 0, 0, "R7");
    flush = 1;
    cycle(1, 8'h77, 0, 0, "R7");
    check("R7 count", fill_count, 0);
    check("R7 valid", out_valid, 0);
    cycle(1, 8'h78, 0, 0, "R7");
    check("R7 held", fill_count, 0);
    flush = 0;
    cycle(1, 8'h79, 3'b010, 0, "R7");
    check("R7 resume", fill_count, 1);
    cycle(0, 0, 0, 1, "R7");
    check_level("R7 after");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule